// File: doc/BRIEF.md
# CPU Bus Cycle Classifier

This block sits passively beside an 8-bit microprocessor bus. It watches five sampled active-low control strobes: opcode-cycle marker, read, write, memory request and I/O request. It also watches the 16-bit address bus and the 8-bit data bus. Once per clock it sorts the bus state into one of seven cycle kinds. It raises single-clock events when a bus cycle starts, when it finishes, and when the bus jumps straight from one active kind to a different one.

A bus may be probed without its memory-request or I/O-request line. Two presence flags cover that case. With the memory-request line missing, the block assumes memory request is asserted. With the I/O-request line missing, it assumes I/O request is deasserted.

The block captures the address when a cycle starts. It keeps the last data byte seen while the cycle was active. When the cycle finishes, it reports the direction class of that cycle: an opcode fetch counts as a memory read, and an interrupt acknowledge counts as an I/O read. A cycle that suffered an illegal jump is marked invalid, so that its address and data are discarded. Instruction decoding is left to a consumer downstream.

Top module: `bus_cycle_monitor`

## Requirements
- R1: With memory request asserted, read low gives kind 5 (opcode fetch) when the opcode marker is low and kind 1 (memory read) otherwise. Write low with read high gives kind 2 (memory write). Read takes priority over write.
- R2: With memory request deasserted and I/O request asserted, the opcode marker low gives kind 6 (interrupt acknowledge). Otherwise read low gives kind 3 (I/O read) and write low gives kind 4 (I/O write). Every other strobe state gives kind 0 (none).
- R3: When `mreqPresent` is 0, `mreqN` is ignored and treated as low. When `iorqPresent` is 0, `iorqN` is ignored and treated as high.
- R4: A change from kind 0 to a nonzero kind pulses `beginPulse` for one clock and captures `addrIn` into `cycleAddr`. `cycleAddr` holds its value in every other clock.
- R5: A change from a nonzero kind to kind 0 pulses `endPulse` for one clock. `cycleData` then holds the last `dataIn` sampled while a kind was nonzero. `endClass` holds the class of the finished kind: 0 for kinds 1 and 5, 1 for kind 2, 2 for kinds 3 and 6, and 3 for kind 4.
- R6: A direct change between two different nonzero kinds pulses `illegalPulse` and clears `cycleValid`. `cycleValid` is set by each begin event.
- R7: All outputs are registered. The kind sampled at a clock edge appears on `cycleKind` after that edge. At most one of the three event pulses is high in any clock.
- R8: An active-low reset clears `cycleKind`, all pulses, `cycleAddr`, `cycleData`, `cycleValid` and `endClass` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| m1N | input | 1 | Opcode-cycle marker, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| mreqN | input | 1 | Memory request, active low |
| iorqN | input | 1 | I/O request, active low |
| mreqPresent | input | 1 | 1 when the memory-request line is connected |
| iorqPresent | input | 1 | 1 when the I/O-request line is connected |
| addrIn | input | 16 | Address bus |
| dataIn | input | 8 | Data bus |
| cycleKind | output | 3 | Registered cycle kind (0 none .. 6 interrupt acknowledge) |
| beginPulse | output | 1 | Cycle start event |
| endPulse | output | 1 | Cycle finish event |
| illegalPulse | output | 1 | Direct change between active kinds |
| cycleAddr | output | 16 | Address captured at cycle start |
| cycleData | output | 8 | Last data byte seen during an active cycle |
| cycleValid | output | 1 | Current or last cycle had no illegal jump |
| endClass | output | 2 | Direction class of the last finished cycle |

## Verification
Random strobe patterns cover each control combination against a bench classifier. These include both strobes low together and each presence flag dropped. They separate the priority order of read over write, and of the opcode marker over read and write. Inputs are sometimes held over several clocks, which gives long cycles that tell begin and end events apart from per-sample capture. Other inputs change every clock, which forces back-to-back kind changes that only an illegal-jump detector flags. Directed sequences hit the ignored request lines and a fetch ending after a jump to an I/O write.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_MEMRD  = 3'd1,
    KIND_MEMWR  = 3'd2,
    KIND_IORD   = 3'd3,
    KIND_IOWR   = 3'd4,
    KIND_FETCH  = 3'd5,
    KIND_INTACK = 3'd6
  } kind_e;

  typedef enum logic [1:0] {
    CLASS_MEMRD = 2'd0,
    CLASS_MEMWR = 2'd1,
    CLASS_IORD  = 2'd2,
    CLASS_IOWR  = 2'd3
  } class_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capAddr;
    logic   capData;
    logic   setValid;
    logic   clrValid;
    logic   capClass;
    class_e reportClass;
  } strobe_t;

endpackage

// File: rtl/bcm_ctrl.sv
module bcm_ctrl
  import bcm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    m1N,
  input  logic    rdN,
  input  logic    wrN,
  input  logic    mreqN,
  input  logic    iorqN,
  input  logic    mreqPresent,
  input  logic    iorqPresent,
  output kind_e   kindQ,
  output logic    beginPulse,
  output logic    endPulse,
  output logic    illegalPulse,
  output strobe_t strobes
);

  logic  mreqEff;
  logic  iorqEff;
  kind_e kindNow;
  logic  isBegin;
  logic  isEnd;
  logic  isIllegal;

  // absent request lines take fixed default levels
  always_comb begin
    mreqEff = mreqPresent ? mreqN : 1'b0;
    iorqEff = iorqPresent ? iorqN : 1'b1;
  end

  always_comb begin
    kindNow = KIND_NONE;
    if (!mreqEff) begin
      if (!rdN)      kindNow = m1N ? KIND_MEMRD : KIND_FETCH;
      else if (!wrN) kindNow = KIND_MEMWR;
    end else if (!iorqEff) begin
      if (!m1N)      kindNow = KIND_INTACK;
      else if (!rdN) kindNow = KIND_IORD;
      else if (!wrN) kindNow = KIND_IOWR;
    end
  end

  always_comb begin
    isBegin   = (kindQ == KIND_NONE) && (kindNow != KIND_NONE);
    isEnd     = (kindQ != KIND_NONE) && (kindNow == KIND_NONE);
    isIllegal = (kindQ != KIND_NONE) && (kindNow != KIND_NONE) && (kindQ != kindNow);
  end

  always_comb begin
    strobes.capAddr  = isBegin;
    strobes.capData  = (kindNow != KIND_NONE);
    strobes.setValid = isBegin;
    strobes.clrValid = isIllegal;
    strobes.capClass = isEnd;
    unique case (kindQ)
      KIND_MEMWR:             strobes.reportClass = CLASS_MEMWR;
      KIND_IORD, KIND_INTACK: strobes.reportClass = CLASS_IORD;
      KIND_IOWR:              strobes.reportClass = CLASS_IOWR;
      default:                strobes.reportClass = CLASS_MEMRD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ        <= KIND_NONE;
      beginPulse   <= 1'b0;
      endPulse     <= 1'b0;
      illegalPulse <= 1'b0;
    end else begin
      kindQ        <= kindNow;
      beginPulse   <= isBegin;
      endPulse     <= isEnd;
      illegalPulse <= isIllegal;
    end
  end

  AST_BEGIN_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    beginPulse |-> (kindQ != KIND_NONE) && ($past(kindQ) == KIND_NONE)); // R4
  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    endPulse |-> (kindQ == KIND_NONE) && ($past(kindQ) != KIND_NONE)); // R5
  AST_ILLEGAL_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |-> (kindQ != KIND_NONE) && ($past(kindQ) != KIND_NONE)
                     && (kindQ != $past(kindQ))); // R6
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({beginPulse, endPulse, illegalPulse})); // R7
  AST_KIND_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    kindQ != 3'd7); // R1

endmodule

// File: rtl/bcm_datapath.sv
module bcm_datapath
  import bcm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] cycleAddr,
  output logic [DATA_W-1:0] cycleData,
  output logic              cycleValid,
  output class_e            endClass
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleAddr  <= '0;
      cycleData  <= '0;
      cycleValid <= 1'b0;
      endClass   <= CLASS_MEMRD;
    end else begin
      if (strobes.capAddr)  cycleAddr <= addrIn;
      if (strobes.capData)  cycleData <= dataIn;
      if (strobes.clrValid)      cycleValid <= 1'b0;
      else if (strobes.setValid) cycleValid <= 1'b1;
      if (strobes.capClass) endClass <= strobes.reportClass;
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capAddr |=> $stable(cycleAddr)); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capData |=> $stable(cycleData)); // R5
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrValid |=> !cycleValid); // R6
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setValid |=> cycleValid); // R6

endmodule

// File: rtl/bus_cycle_monitor.sv
module bus_cycle_monitor
  import bcm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              m1N,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              mreqN,
  input  logic              iorqN,
  input  logic              mreqPresent,
  input  logic              iorqPresent,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [2:0]        cycleKind,
  output logic              beginPulse,
  output logic              endPulse,
  output logic              illegalPulse,
  output logic [ADDR_W-1:0] cycleAddr,
  output logic [DATA_W-1:0] cycleData,
  output logic              cycleValid,
  output logic [1:0]        endClass
);

  kind_e   kindQ;
  strobe_t strobes;
  class_e  endClassQ;

  bcm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .m1N(m1N), .rdN(rdN), .wrN(wrN),
    .mreqN(mreqN), .iorqN(iorqN),
    .mreqPresent(mreqPresent), .iorqPresent(iorqPresent),
    .kindQ(kindQ), .beginPulse(beginPulse), .endPulse(endPulse),
    .illegalPulse(illegalPulse), .strobes(strobes)
  );

  bcm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .addrIn(addrIn), .dataIn(dataIn),
    .cycleAddr(cycleAddr), .cycleData(cycleData),
    .cycleValid(cycleValid), .endClass(endClassQ)
  );

  assign cycleKind = kindQ;
  assign endClass  = endClassQ;

endmodule

// File: tb/bus_cycle_monitor_bench.sv
module bus_cycle_monitor_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic m1N = 1'b1, rdN = 1'b1, wrN = 1'b1, mreqN = 1'b1, iorqN = 1'b1;
  logic mreqPresent = 1'b1, iorqPresent = 1'b1;
  logic [15:0] addrIn = '0;
  logic [7:0]  dataIn = '0;
  logic [2:0]  cycleKind;
  logic beginPulse, endPulse, illegalPulse, cycleValid;
  logic [15:0] cycleAddr;
  logic [7:0]  cycleData;
  logic [1:0]  endClass;

  int tests = 0;
  int fails = 0;

  // expected state
  int          expKind = 0;
  logic        expBegin = 0, expEnd = 0, expIll = 0, expValid = 0;
  logic [15:0] expAddr = '0;
  logic [7:0]  expData = '0;
  logic [1:0]  expClass = '0;

  always #4 clk = ~clk;

  bus_cycle_monitor u_bus_cycle_monitor (
    .clk(clk), .rstN(rstN), .m1N(m1N), .rdN(rdN), .wrN(wrN),
    .mreqN(mreqN), .iorqN(iorqN),
    .mreqPresent(mreqPresent), .iorqPresent(iorqPresent),
    .addrIn(addrIn), .dataIn(dataIn),
    .cycleKind(cycleKind), .beginPulse(beginPulse), .endPulse(endPulse),
    .illegalPulse(illegalPulse), .cycleAddr(cycleAddr), .cycleData(cycleData),
    .cycleValid(cycleValid), .endClass(endClass)
  );

  // R1 R2 R3: bench classifier
  function automatic int kindOf(logic m1, logic rd, logic wr, logic mq, logic iq,
                                logic mqP, logic iqP);
    logic memOn, ioOn;
    memOn = mqP ? !mq : 1'b1;
    ioOn  = iqP ? !iq : 1'b0;
    if (memOn) begin
      if (!rd) return m1 ? 1 : 5;
      if (!wr) return 2;
      return 0;
    end
    if (ioOn) begin
      if (!m1) return 6;
      if (!rd) return 3;
      if (!wr) return 4;
    end
    return 0;
  endfunction

  // R5: class mapping
  function automatic logic [1:0] classOf(int k);
    case (k)
      2:       return 2'd1;
      3, 6:    return 2'd2;
      4:       return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    check("R1/R2 cycleKind", int'(cycleKind), expKind);
    check("R4 beginPulse", int'(beginPulse), int'(expBegin));
    check("R5 endPulse", int'(endPulse), int'(expEnd));
    check("R6 illegalPulse", int'(illegalPulse), int'(expIll));
    check("R4 cycleAddr", int'(cycleAddr), int'(expAddr));
    check("R5 cycleData", int'(cycleData), int'(expData));
    check("R6 cycleValid", int'(cycleValid), int'(expValid));
    check("R5 endClass", int'(endClass), int'(expClass));
  endtask

  // drive one sample, update model, check after the edge (R7)
  task automatic step(logic m1, logic rd, logic wr, logic mq, logic iq,
                      logic mqP, logic iqP, logic [15:0] a, logic [7:0] d);
    int kn;
    @(negedge clk);
    m1N = m1; rdN = rd; wrN = wr; mreqN = mq; iorqN = iq;
    mreqPresent = mqP; iorqPresent = iqP; addrIn = a; dataIn = d;
    kn = kindOf(m1, rd, wr, mq, iq, mqP, iqP);
    expBegin = (expKind == 0) && (kn != 0);
    expEnd   = (expKind != 0) && (kn == 0);
    expIll   = (expKind != 0) && (kn != 0) && (kn != expKind);
    if (expBegin) expAddr = a;
    if (kn != 0)  expData = d;
    if (expIll) expValid = 1'b0;
    else if (expBegin) expValid = 1'b1;
    if (expEnd) expClass = classOf(expKind);
    expKind = kn;
    @(posedge clk);
    #1;
    checkAll();
  endtask

  task automatic idle();
    step(1, 1, 1, 1, 1, 1, 1, 16'h0, 8'h0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic m1, rd, wr, mq, iq, mqP, iqP;
    logic [15:0] a;
    logic [7:0]  d;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    checkAll(); // R8 reset values
    @(negedge clk);
    rstN = 1'b1;

    // R1: fetch, then end with memory-read class
    step(0, 0, 1, 0, 1, 1, 1, 16'h1234, 8'hCB);
    step(0, 0, 1, 0, 1, 1, 1, 16'h9999, 8'h3E);
    idle();
    check("R5 fetch reports memory read", int'(endClass), 0);
    check("R4 address from first sample", int'(cycleAddr), 16'h1234);
    // R1: read beats write
    step(1, 0, 0, 0, 1, 1, 1, 16'h0042, 8'h11);
    check("R1 read priority", int'(cycleKind), 1);
    idle();
    // R2: interrupt acknowledge, class reports I/O read
    step(0, 1, 1, 1, 0, 1, 1, 16'h00FF, 8'hC7);
    idle();
    check("R2 intack class", int'(endClass), 2);
    // R3: memory request absent, mreqN high ignored
    step(1, 0, 1, 1, 1, 0, 1, 16'hABCD, 8'h55);
    check("R3 mreq default asserted", int'(cycleKind), 1);
    idle();
    // R3: I/O request absent, iorqN low ignored
    step(1, 0, 1, 1, 0, 1, 0, 16'h0001, 8'h77);
    check("R3 iorq default deasserted", int'(cycleKind), 0);
    idle();
    // R6: fetch jumps to I/O write, then ends
    step(0, 0, 1, 0, 1, 1, 1, 16'h2000, 8'h01);
    step(1, 1, 0, 1, 0, 1, 1, 16'h3000, 8'h02);
    check("R6 jump flagged", int'(illegalPulse), 1);
    check("R6 valid cleared", int'(cycleValid), 0);
    idle();
    check("R5 last active data", int'(cycleData), 8'h02);
    check("R5 class of final kind", int'(endClass), 3);

    // random stimulus, sometimes held over several clocks
    {m1, rd, wr, mq, iq, mqP, iqP} = 7'h7F;
    a = '0; d = '0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 2) != 0) begin
        if ($urandom_range(0, 3) == 0) {m1, rd, wr, mq, iq} = 5'h1F;
        else {m1, rd, wr, mq, iq} = 5'($urandom);
        mqP = ($urandom_range(0, 9) != 0);
        iqP = ($urandom_range(0, 9) != 0);
        a = 16'($urandom);
      end
      d = 8'($urandom);
      step(m1, rd, wr, mq, iq, mqP, iqP, a, d);
    end

    // R8: reset mid-cycle clears everything
    step(1, 1, 0, 0, 1, 1, 1, 16'h5A5A, 8'hA5);
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    check("R8 kind after reset", int'(cycleKind), 0);
    check("R8 addr after reset", int'(cycleAddr), 0);
    check("R8 valid after reset", int'(cycleValid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule